// File: doc/BRIEF.md
# Block-Transfer Serial Configuration Register Slave

This block is the configuration store of a clock generator, reached over a two-wire SMBus-style serial link. The bus clock and data lines arrive as plain inputs, are synchronised to the core clock, and are decoded into start, stop and bit events. The slave pulls data low through a single open-drain enable. It never drives the line high. Access is only by block transfers. A write carries the slave address, a command byte of zero, a byte count and then data bytes. The data bytes always land at index 0 and then upward. A read repeats the address and command, issues a repeated start and the read address, and then streams out a count byte followed by the register bytes, lowest index first and most significant bit first.

The register bytes drive the clock generator's control outputs directly: output enables, stop-mode selections and spread settings. Some bit positions are not storage. They mirror live pins (the CPU stop pin, the three frequency-select pins and the current-multiplier pin) at the moment the byte is sent. One stop-control bit reads back combined with its pin. A fixed signature byte takes writes and discards them. A stop condition, or the clock line held low for too long, returns the slave to idle with the data line released.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The 7-bit address 0x69 (address byte 0xD2 for write, 0xD3 for read) is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the slave keeps SDA released until the next start.
- R2: The command byte 0x00 is acknowledged. Any other command is not acknowledged, and SDA stays released for the rest of that transfer.
- R3: In a block write, the byte count after the command is acknowledged. Each following data byte is acknowledged and stored at index 0, 1, 2 and so on, whatever count value was sent.
- R4: In a block read, after a repeated start and 0xD3, the slave sends a count byte equal to the number of implemented bytes (10). It then sends bytes from index 0 upward, MSB first, for as long as the master acknowledges. After a master NACK it leaves SDA released.
- R5: After reset, regs_o bytes 0..9 read 08,07,7F,C7,3F,40,00,00,00,00 (byte k at bits 8k+7:8k), pci_run_o equals pci_stop_n_i, and SDA is released.
- R6: The following bits are read-only and reflect live pins when the byte is sent: byte 0 bit 4 reads cpu_stop_n_i, byte 0 bits 2:0 read sel_i, and byte 1 bit 7 reads mult_i. Writes to those positions are discarded. The writable positions are byte 0 bits 7:5 and 3, and byte 1 bits 6:0.
- R7: Byte 0 bit 3 is an internal stop-control bit that resets to 1. It reads back as the AND of pci_stop_n_i and that bit, and pci_run_o carries the same AND.
- R8: Byte 6 reads 0x11, with the vendor nibble 0001 in bits 7:4 and 0001 in bits 3:0. Writes to it are acknowledged and discarded.
- R9: Bytes 2..5, 8 and 9 are fully writable. Byte 7 and every index from 10 upward read 0x00. Writes to them are acknowledged and discarded.
- R10: A stop condition returns the slave to idle and releases SDA. If SCL stays low for TIMEOUT_CYC core clocks during a transfer, the slave also returns to idle and releases SDA, even in the middle of an acknowledge.
- R11: The master may stop after any complete data byte. Bytes already sent keep their new values, and all other bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cpu_stop_n_i | input | 1 | CPU clock stop pin, mirrored into byte 0 bit 4 |
| pci_stop_n_i | input | 1 | PCI clock stop pin, combined into byte 0 bit 3 |
| sel_i | input | 3 | Frequency-select pins, mirrored into byte 0 bits 2:0 |
| mult_i | input | 1 | Current-multiplier pin, mirrored into byte 1 bit 7 |
| regs_o | output | NUM_BYTES*8 | Stored register image; byte k at bits 8k+7:8k, read-only positions 0 |
| pci_run_o | output | 1 | 1 when stoppable PCI clocks run (pin AND internal bit) |

## Verification
Two events can coincide in this block. The first is the SCL-low timeout expiring while the slave is holding its acknowledge low. The bench provokes this by parking SCL low right after the address byte. It first confirms that SDA is being pulled, then expects the release to win once TIMEOUT_CYC has passed, and then expects a normal transfer to work afterwards. The second is a write that has just landed in byte 0 meeting live pin values in the same byte image. The bench writes the internal stop bit and then flips the stop pin. It judges the read-back bit and pci_run_o against the AND computed by its model, with the mirrored pin bits taken at their current levels.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } link_st_t;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_DATA
  } byte_role_t;

  // Reset image of each byte; read-only positions hold 0.
  function automatic logic [7:0] cfg_default(input int idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      5:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // Bits a host write may change.
  function automatic logic [7:0] cfg_wmask(input int idx);
    case (idx)
      0:       return 8'hE8;
      1:       return 8'h7F;
      2, 3, 4, 5, 8, 9: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_m, sda_m, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      sda_m <= 1'b1;
      scl_s <= 1'b1;
      sda_s <= 1'b1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i;
      sda_m <= sda_i;
      scl_s <= scl_m;
      sda_s <= sda_m;
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_p;
    scl_fall  = ~scl_s & scl_p;
    bus_start = scl_s & scl_p & sda_p & ~sda_s;
    bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
  end

endmodule

// File: rtl/smbus_link.sv
module smbus_link
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         NUM_BYTES   = 10,
  parameter int         TIMEOUT_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);

  localparam int         TW       = $clog2(TIMEOUT_CYC + 1);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_BYTES);
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

  link_st_t   st_q, st_d;
  byte_role_t role_q, role_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] ptr_q, ptr_d;
  logic       cmd_q, cmd_d;
  logic       rd_q, rd_d;
  logic       more_q, more_d;
  logic       oe_q, oe_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic       tmo_run, tmo_hit;
  logic [7:0] ptr_inc;

  always_comb begin
    tmo_run = (st_q != ST_IDLE) && !scl_s;
    tmo_hit = tmo_run && (tmo_q == TMO_LAST);
    tmo_d   = (tmo_run && !tmo_hit) ? tmo_q + 1'b1 : '0;
    ptr_inc = (ptr_q == 8'hFF) ? ptr_q : ptr_q + 8'd1;
  end

  always_comb begin
    st_d   = st_q;
    role_d = role_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    cmd_d  = cmd_q;
    rd_d   = rd_q;
    more_d = more_q;
    oe_d   = oe_q;
    wr_en  = 1'b0;
    if (bus_start) begin
      st_d   = ST_RX;
      bit_d  = 4'd0;
      role_d = RL_ADDR;
      oe_d   = 1'b0;
      rd_d   = 1'b0;
    end else if (bus_stop || tmo_hit) begin
      st_d  = ST_IDLE;
      oe_d  = 1'b0;
      cmd_d = 1'b0;
      rd_d  = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && (bit_q < 4'd8)) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && (bit_q == 4'd8)) begin
            st_d = ST_RXACK;
            oe_d = 1'b1;
            case (role_q)
              RL_ADDR: begin
                if (sh_q[7:1] != SLAVE_ADDR) begin
                  st_d = ST_WAIT;
                  oe_d = 1'b0;
                end else if (!sh_q[0]) begin
                  role_d = RL_CMD;
                end else if (cmd_q) begin
                  rd_d = 1'b1;
                end else begin
                  st_d = ST_WAIT;
                  oe_d = 1'b0;
                end
              end
              RL_CMD: begin
                if (sh_q == 8'h00) begin
                  cmd_d  = 1'b1;
                  role_d = RL_CNT;
                end else begin
                  st_d = ST_WAIT;
                  oe_d = 1'b0;
                end
              end
              RL_CNT: begin
                role_d = RL_DATA;
                ptr_d  = 8'd0;
              end
              default: begin
                wr_en = 1'b1;
                ptr_d = ptr_inc;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              st_d  = ST_TX;
              sh_d  = CNT_BYTE;
              oe_d  = ~CNT_BYTE[7];
              bit_d = 4'd1;
              ptr_d = 8'd0;
            end else begin
              st_d  = ST_RX;
              oe_d  = 1'b0;
              bit_d = 4'd0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d = 1'b0;
              st_d = ST_TXACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              bit_d = bit_q + 4'd1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            more_d = ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              st_d  = ST_TX;
              sh_d  = rd_data;
              oe_d  = ~rd_data[7];
              bit_d = 4'd1;
              ptr_d = ptr_inc;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      role_q <= RL_ADDR;
      bit_q  <= 4'd0;
      sh_q   <= 8'd0;
      ptr_q  <= 8'd0;
      cmd_q  <= 1'b0;
      rd_q   <= 1'b0;
      more_q <= 1'b0;
      oe_q   <= 1'b0;
      tmo_q  <= '0;
    end else begin
      st_q   <= st_d;
      role_q <= role_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      cmd_q  <= cmd_d;
      rd_q   <= rd_d;
      more_q <= more_d;
      oe_q   <= oe_d;
      tmo_q  <= tmo_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_addr = ptr_q;
  assign wr_data = sh_q;
  assign rd_addr = ptr_q;

  // R1: never pulls the line while idle
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe);
  // R10: stop releases the line
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);
  // R10: timeout releases the line
  a_r10_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!sda_oe && (st_q == ST_IDLE)));
  // R4: the slave only starts pulling while the clock line is low
  a_r4_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R3: each stored data byte moves the index up by one
  a_r3_index_advance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ptr_q == $past(ptr_q) + 8'd1) || ($past(ptr_q) == 8'hFF)));

endmodule

// File: rtl/smbus_cfg_regfile.sv
module smbus_cfg_regfile
  import smbus_cfg_pkg::*;
#(
  parameter int         NUM_BYTES   = 10,
  parameter logic [3:0] VENDOR_CODE = 4'h1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [7:0]             rd_addr,
  output logic [7:0]             rd_data,
  input  logic                   cpu_stop_n_i,
  input  logic                   pci_stop_n_i,
  input  logic [2:0]             sel_i,
  input  logic                   mult_i,
  output logic [NUM_BYTES*8-1:0] regs_o,
  output logic                   pci_run_o
);

  localparam logic [7:0] CNT_BYTE = 8'(NUM_BYTES);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [7:0] DEF  = cfg_default(g);
    localparam logic [7:0] MASK = cfg_wmask(g);
    logic [7:0] q, d;
    logic       hit;

    always_comb begin
      hit = wr_en && (wr_addr == 8'(g));
      d   = hit ? ((q & ~MASK) | (wr_data & MASK)) : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= DEF;
      else        q <= d;
    end

    assign regs_o[g*8 +: 8] = q;
  end

  logic [7:0] base;

  always_comb begin
    base = 8'h00;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (rd_addr == 8'(i)) base = regs_o[i*8 +: 8];
    end
    case (rd_addr)
      8'd0:    rd_data = {base[7:5], cpu_stop_n_i, pci_stop_n_i & base[3], sel_i};
      8'd1:    rd_data = {mult_i, base[6:0]};
      8'd6:    rd_data = {VENDOR_CODE, 4'b0001};
      default: rd_data = base;
    endcase
  end

  assign pci_run_o = pci_stop_n_i & regs_o[3];

  // R8: writes to the signature byte leave storage untouched
  a_r8_sig_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 8'd6)) |=> $stable(regs_o));
  // R9: writes to the dead byte or beyond the range leave storage untouched
  a_r9_dead_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_addr == 8'd7) || (wr_addr >= CNT_BYTE))) |=> $stable(regs_o));
  // R7: internal stop bit low forces the run flag low
  a_r7_stop_and: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_o[3] |-> !pci_run_o);

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         NUM_BYTES   = 10,
  parameter logic [3:0] VENDOR_CODE = 4'h1,
  parameter int         TIMEOUT_CYC = 50000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic                   cpu_stop_n_i,
  input  logic                   pci_stop_n_i,
  input  logic [2:0]             sel_i,
  input  logic                   mult_i,
  output logic [NUM_BYTES*8-1:0] regs_o,
  output logic                   pci_run_o
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  smbus_line_sync u_sync (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  smbus_link #(
    .SLAVE_ADDR  (SLAVE_ADDR),
    .NUM_BYTES   (NUM_BYTES),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_link (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  smbus_cfg_regfile #(
    .NUM_BYTES   (NUM_BYTES),
    .VENDOR_CODE (VENDOR_CODE)
  ) u_regs (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .cpu_stop_n_i (cpu_stop_n_i),
    .pci_stop_n_i (pci_stop_n_i),
    .sel_i        (sel_i),
    .mult_i       (mult_i),
    .regs_o       (regs_o),
    .pci_run_o    (pci_run_o)
  );

endmodule

// File: tb/smbus_cfg_slave_tb_top.sv
module smbus_cfg_slave_tb_top;

  localparam int NB  = 10;
  localparam int Q   = 5;
  localparam int TMO = 600;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, cpu_n, pci_n, mult;
  logic [2:0] sel;
  logic sda_oe;
  logic [NB*8-1:0] regs;
  logic pci_run;
  wire  sda_line = sda_m & ~sda_oe;

  smbus_cfg_slave #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cpu_stop_n_i(cpu_n), .pci_stop_n_i(pci_n),
    .sel_i(sel), .mult_i(mult), .regs_o(regs), .pci_run_o(pci_run));

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] st [NB];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  function automatic logic [7:0] dflt(int i);
    case (i) 0: return 8'h08; 1: return 8'h07; 2: return 8'h7F; 3: return 8'hC7;
      4: return 8'h3F; 5: return 8'h40; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] wmask(int i);
    case (i) 0: return 8'hE8; 1: return 8'h7F; 2,3,4,5,8,9: return 8'hFF;
      default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] exp_rd(int i);
    if (i >= NB) return 8'h00;
    case (i)
      0: return {st[0][7:5], cpu_n, pci_n & st[0][3], sel};
      1: return {mult, st[1][6:0]};
      6: return 8'h11;
      default: return st[i];
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask
  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); acked = !sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = !give_ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic model_write(input int n);
    for (int k = 0; k < n; k++)
      if (k < NB) st[k] = (st[k] & ~wmask(k)) | (wbuf[k] & wmask(k));
  endtask

  task automatic block_write(input int cnt, input int n);
    bit a;
    bus_start();
    send_byte(8'hD2, a); chk("R1", "write address ack", a, 1);
    send_byte(8'h00, a); chk("R2", "command ack", a, 1);
    send_byte(8'(cnt), a); chk("R3", "count ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); chk("R3", "data ack", a, 1);
    end
    bus_stop();
    model_write(n);
  endtask

  task automatic block_read(input int n);
    bit a;
    logic [7:0] c;
    bus_start();
    send_byte(8'hD2, a); chk("R1", "addr ack", a, 1);
    send_byte(8'h00, a); chk("R2", "cmd ack", a, 1);
    bus_start();
    send_byte(8'hD3, a); chk("R1", "read address ack", a, 1);
    recv_byte(n > 0, c); chk("R4", "count byte", c, NB);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, rbuf[k]);
      if (k == 0 || k == 1) chk("R6", $sformatf("byte %0d", k), rbuf[k], exp_rd(k));
      else if (k == 6)      chk("R8", "signature", rbuf[k], exp_rd(k));
      else if (k == 7 || k >= NB) chk("R9", $sformatf("dead byte %0d", k), rbuf[k], 8'h00);
      else                  chk("R4", $sformatf("byte %0d", k), rbuf[k], exp_rd(k));
    end
    chk("R4", "released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic chk_image(input string req);
    for (int k = 0; k < NB; k++) chk(req, $sformatf("regs_o byte %0d", k), regs[k*8 +: 8], st[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    cpu_n = 1'b1; pci_n = 1'b1; sel = 3'b101; mult = 1'b0;
    for (int k = 0; k < NB; k++) st[k] = dflt(k);
    tick(4); rst_n = 1'b1; tick(4);

    // R5 reset state
    chk_image("R5");
    chk("R5", "sda released", sda_oe, 0);
    chk("R5", "pci_run", pci_run, 1);
    block_read(NB);

    // R1 foreign address ignored
    bus_start();
    send_byte(8'hA4, a); chk("R1", "foreign address nack", a, 0);
    send_byte(8'h00, a); chk("R1", "stays released", a, 0);
    bus_stop();

    // R2 wrong command ignored
    bus_start();
    send_byte(8'hD2, a); chk("R1", "address ack", a, 1);
    send_byte(8'h05, a); chk("R2", "bad command nack", a, 0);
    send_byte(8'h01, a); chk("R2", "following byte nack", a, 0);
    bus_stop();
    chk_image("R2");

    // R6/R8/R9 writes of all ones, running past the end
    for (int k = 0; k < 12; k++) wbuf[k] = 8'hFF;
    block_write(12, 12);
    chk_image("R9");
    sel = 3'b010; cpu_n = 1'b0; mult = 1'b1;
    block_read(12);

    // R7 internal stop bit against pin
    wbuf[0] = 8'h00;
    block_write(1, 1);
    chk("R7", "run with bit cleared", pci_run, 0);
    block_read(1);
    wbuf[0] = 8'h08;
    block_write(1, 1);
    pci_n = 1'b0; tick(2);
    chk("R7", "run with pin low", pci_run, 0);
    block_read(1);
    pci_n = 1'b1; tick(2);
    chk("R7", "run with both high", pci_run, 1);
    block_read(1);

    // R11 stop after two of five announced bytes
    wbuf[0] = 8'hA0; wbuf[1] = 8'h15;
    block_write(5, 2);
    chk_image("R11");
    block_read(4);

    // R10 timeout in the middle of the address acknowledge
    bus_start();
    send_bits(8'hD2);
    tick(Q);
    chk("R1", "ack pulled before timeout", sda_oe, 1);
    tick(TMO + 20);
    chk("R10", "released after timeout", sda_oe, 0);
    scl_m = 1'b1; sda_m = 1'b1; tick(4*Q);
    block_read(2);

    // R10 stop releases
    chk("R10", "idle after stop", sda_oe, 0);

    // random block writes and reads
    for (int it = 0; it < 12; it++) begin
      int n, m;
      n = $urandom_range(0, 11);
      m = $urandom_range(0, 11);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      block_write($urandom_range(0, 255), n);
      chk_image("R3");
      cpu_n = 1'($urandom); pci_n = 1'($urandom); sel = 3'($urandom); mult = 1'($urandom);
      tick(2);
      chk("R7", "random run flag", pci_run, pci_n & st[0][3]);
      block_read(m);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule